// File: doc/BRIEF.md
# LIN-Capable Asynchronous Serial Port

This block is a full-duplex asynchronous serial port with 8N1 frames, least significant bit first, and an idle-high line. It has one 8-bit data register and one 16-bit status register, both reached through a small register bus. The receiver takes 8 samples per bit, with the sample rate set by a divider input. It confirms a start bit at mid-bit and reads every data bit and the stop bit at mid-bit. It reports framing errors, overruns and break characters. A break is longer in LIN mode.

The transmitter uses a one-byte holding register in front of a shift register. Software polls the transmit-empty flag before it writes a byte. The receive-side flags are sticky. A flag clears only when software reads the status register while the flag is set and then reads the data register. An interrupt output is high while the receive-full, break or overrun flag is set. A measurement-mode input, when high, stops all receive flag updates.

The register bus has two addresses. Address 0 is status. Address 1 is data: a write queues a transmit byte and a read returns the received byte. Read data appears on `reg_rdata` one cycle after the read strobe.

Top module: `lin_uart`

## Requirements
- R1: While reset is high, `tx` is 1, `irq` is 0 and `reg_rdata` is 0. After reset with no traffic, a status read returns 0x00C0 (transmit-empty and transmit-complete set).
- R2: One bit lasts 8 × `baud_div` clocks. A low pulse on `rx` shorter than half a bit is not taken as a start bit and sets no flag.
- R3: After a frame whose stop bit is 1, receive-full (status bit 5) sets about 1/8 bit after the middle of the stop bit, and a data read (address 1) returns the byte in bits 7:0.
- R4: If the stop-bit position is sampled as 0, framing error (status bit 0) sets together with receive-full, and the received byte is still stored.
- R5: A start bit followed by 8 zero data bits and a zero stop position is a break; with `lin_mode` high, a ninth zero bit is also needed. A break sets break (bit 4), receive-full and framing error, and clears the data register to 0. In LIN mode, a zero byte with a zero stop bit followed by a 1 gives only framing error and receive-full.
- R6: Receive-full, break, overrun and framing error clear only when a status read sees the flag set and a data read follows. A data read with no such status read before it changes nothing.
- R7: If a frame or break completes while receive-full is still set, overrun (bit 3) sets, the new byte is discarded and the old byte is kept.
- R8: A data write while transmit-empty (bit 7) is 1 queues the byte, which is sent as 8N1 LSB first. A write made while the holding register is full is ignored. Transmit-complete (bit 6) is 0 while a frame is being shifted out.
- R9: While `meas_mode` is high, completed receive frames and breaks change no flag and no data.
- R10: `irq` is 1 exactly when receive-full, break or overrun is set, one cycle behind the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_div | input | DIV_W | Clocks per 1/8 bit (0 or 1 means every clock) |
| lin_mode | input | 1 | Requires a ninth zero bit for a break |
| meas_mode | input | 1 | Suppresses receive flag updates |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status, 1 = data |
| reg_wdata | input | 8 | Write data (transmit byte) |
| reg_rdata | output | 16 | Read data, one cycle after the strobe |
| rx | input | 1 | Serial receive line |
| tx | output | 1 | Serial transmit line |
| irq | output | 1 | Receive interrupt |

## Verification
The bench keeps the default widths (16-bit divider, 8 samples per bit) and drives `baud_div` = 4. A bit then lasts 32 clocks, so the bench can run about fifty whole frames, breaks in both modes and transmit frames well inside its cycle budget. This short bit time also lets the bench place a 6-clock glitch well below the half-bit confirmation point. The bench captures the transmit line at 32-clock spacing and checks that the first, shorter bit still lands mid-bit.

// File: rtl/lin_uart_pkg.sv
package lin_uart_pkg;
  localparam int ST_TDRE = 7;
  localparam int ST_TC   = 6;
  localparam int ST_RDRF = 5;
  localparam int ST_BRK  = 4;
  localparam int ST_OVR  = 3;
  localparam int ST_FE   = 0;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_EXTRA, RX_POST
  } rx_state_t;
endpackage

// File: rtl/lin_uart_baud.sv
module lin_uart_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] reload;

  assign reload = (div == '0) ? '0 : div - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= reload;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/lin_uart_rx.sv
module lin_uart_rx
  import lin_uart_pkg::*;
#(
  parameter int OSR = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rx_in,
  input  logic       lin_mode,
  output logic       done,
  output logic [7:0] data,
  output logic       fe,
  output logic       brk
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_t   st;
  logic        s1, s2, seen_hi;
  logic [CW-1:0] cnt;
  logic [2:0]  idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1; s2 <= 1'b1;
      st <= RX_IDLE; seen_hi <= 1'b0;
      cnt <= '0; idx <= '0;
      data <= '0; fe <= 1'b0; brk <= 1'b0; done <= 1'b0;
    end else begin
      s1 <= rx_in;
      s2 <= s1;
      done <= 1'b0;
      if (tick) begin
        case (st)
          RX_IDLE: begin
            if (s2) seen_hi <= 1'b1;
            else if (seen_hi) begin
              st <= RX_START; cnt <= '0; seen_hi <= 1'b0;
            end
          end
          RX_START: begin
            if (cnt == MID) begin
              cnt <= '0; idx <= '0;
              if (!s2) st <= RX_DATA;
              else begin st <= RX_IDLE; seen_hi <= 1'b1; end
            end else cnt <= cnt + 1'b1;
          end
          RX_DATA: begin
            if (cnt == LAST) begin
              cnt  <= '0;
              data <= {s2, data[7:1]};
              if (idx == 3'd7) st <= RX_STOP;
              idx <= idx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          RX_STOP: begin
            if (cnt == LAST) begin
              cnt <= '0;
              fe  <= !s2;
              brk <= !s2 && (data == '0) && !lin_mode;
              st  <= (!s2 && (data == '0) && lin_mode) ? RX_EXTRA : RX_POST;
            end else cnt <= cnt + 1'b1;
          end
          RX_EXTRA: begin
            if (cnt == LAST) begin
              cnt <= '0;
              brk <= !s2;
              st  <= RX_POST;
            end else cnt <= cnt + 1'b1;
          end
          default: begin
            done <= 1'b1;
            st   <= RX_IDLE;
          end
        endcase
      end
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
    (st == RX_DATA && $past(st) == RX_START) |-> !$past(s2));

  p_brk_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (done && brk) |-> (fe && data == '0));
endmodule

// File: rtl/lin_uart_tx.sv
module lin_uart_tx #(
  parameter int OSR = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wr_req,
  input  logic [7:0] wr_data,
  output logic       tdre,
  output logic       tc,
  output logic       tx
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic          hold_full, busy;
  logic [7:0]    hold, sh;
  logic [3:0]    bitn;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0; hold <= '0; busy <= 1'b0; sh <= '0;
      bitn <= '0; cnt <= '0; tx <= 1'b1; tdre <= 1'b0; tc <= 1'b0;
    end else begin
      tdre <= !hold_full;
      tc   <= !busy && !hold_full;
      if (wr_req && !hold_full) begin
        hold      <= wr_data;
        hold_full <= 1'b1;
      end
      if (!busy && hold_full) begin
        busy <= 1'b1; sh <= hold; hold_full <= 1'b0;
        tx <= 1'b0; bitn <= '0; cnt <= '0;
      end else if (busy && tick) begin
        if (cnt == LAST) begin
          cnt <= '0;
          if (bitn == 4'd9) busy <= 1'b0;
          else begin
            bitn <= bitn + 1'b1;
            if (bitn == 4'd8) tx <= 1'b1;
            else begin
              tx <= sh[0];
              sh <= sh >> 1;
            end
          end
        end else cnt <= cnt + 1'b1;
      end
    end
  end

  p_tc_low_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> !tc);

  p_idle_high_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx);
endmodule

// File: rtl/lin_uart.sv
module lin_uart
  import lin_uart_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OSR   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             lin_mode,
  input  logic             meas_mode,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [15:0]      reg_rdata,
  input  logic             rx,
  output logic             tx,
  output logic             irq
);
  logic       tick, rx_done, rx_fe, rx_brk, tdre, tc;
  logic [7:0] rx_data, rxd;
  logic       rdrf, brf, ov, fe;
  logic [3:0] arm;
  logic       rd_stat, rd_data;
  logic [15:0] stat;

  assign rd_stat = reg_rd && !reg_addr;
  assign rd_data = reg_rd && reg_addr;

  lin_uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .div(baud_div), .tick(tick));

  lin_uart_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rx_in(rx), .lin_mode(lin_mode),
    .done(rx_done), .data(rx_data), .fe(rx_fe), .brk(rx_brk));

  lin_uart_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .wr_req(reg_wr && reg_addr),
    .wr_data(reg_wdata), .tdre(tdre), .tc(tc), .tx(tx));

  always_comb begin
    stat          = '0;
    stat[ST_TDRE] = tdre;
    stat[ST_TC]   = tc;
    stat[ST_RDRF] = rdrf;
    stat[ST_BRK]  = brf;
    stat[ST_OVR]  = ov;
    stat[ST_FE]   = fe;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdrf <= 1'b0; brf <= 1'b0; ov <= 1'b0; fe <= 1'b0;
      rxd <= '0; arm <= '0; reg_rdata <= '0; irq <= 1'b0;
    end else begin
      irq <= rdrf || brf || ov;
      if (reg_rd) reg_rdata <= reg_addr ? {8'h00, rxd} : stat;
      if (rd_stat) arm <= {rdrf, brf, ov, fe};
      if (rd_data) begin
        if (arm[3]) rdrf <= 1'b0;
        if (arm[2]) brf  <= 1'b0;
        if (arm[1]) ov   <= 1'b0;
        if (arm[0]) fe   <= 1'b0;
        arm <= '0;
      end
      if (rx_done && !meas_mode) begin
        if (rdrf) ov <= 1'b1;
        else begin
          rdrf <= 1'b1;
          fe   <= rx_fe;
          brf  <= rx_brk;
          rxd  <= rx_brk ? 8'h00 : rx_data;
        end
      end
    end
  end

  p_brk_full_r5: assert property (@(posedge clk) disable iff (rst)
    brf |-> (rdrf && fe));

  p_ov_needs_full_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ov) |-> $past(rdrf));

  p_full_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (rdrf && !rd_data) |=> rdrf);

  p_quiet_meas_r9: assert property (@(posedge clk) disable iff (rst)
    meas_mode |=> !$rose(rdrf));
endmodule

// File: tb/sim_lin_uart.sv
module sim_lin_uart;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int BIT = 8 * DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] baud_div = 16'(DIV);
  logic lin = 1'b0, meas = 1'b0;
  logic reg_rd = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic rx = 1'b1;
  logic tx, irq;

  int total = 0, fails = 0;
  logic m_rdrf = 0, m_brf = 0, m_ov = 0, m_fe = 0;
  logic [7:0] m_data = '0;
  logic [3:0] m_arm = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_uart u0 (
    .clk(clk), .rst(rst), .baud_div(baud_div), .lin_mode(lin),
    .meas_mode(meas), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx(rx), .tx(tx), .irq(irq));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_stat(input logic tdre, input logic tcv);
    return {8'h00, tdre, tcv, m_rdrf, m_brf, m_ov, 2'b00, m_fe};
  endfunction

  task automatic bus_read(input logic a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic bus_write(input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic drive_bit(input logic b);
    rx = b;
    repeat (BIT) @(negedge clk);
  endtask

  // Sends one frame and updates the expected flags (R3, R4, R5, R7, R9)
  task automatic send_frame(input logic [7:0] b, input logic stopb, input logic extra);
    logic brk;
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(b[i]);
    drive_bit(stopb);
    if (lin && b == 0 && !stopb) drive_bit(extra);
    rx = 1'b1;
    repeat (BIT) @(negedge clk);
    brk = !stopb && b == 0 && (!lin || !extra);
    if (!meas) begin
      if (m_rdrf) m_ov = 1'b1;
      else begin
        m_rdrf = 1'b1; m_fe = !stopb; m_brf = brk;
        m_data = brk ? 8'h00 : b;
      end
    end
  endtask

  task automatic model_stat_read();
    m_arm = {m_rdrf, m_brf, m_ov, m_fe};
  endtask

  task automatic model_data_read();
    if (m_arm[3]) m_rdrf = 1'b0;
    if (m_arm[2]) m_brf = 1'b0;
    if (m_arm[1]) m_ov = 1'b0;
    if (m_arm[0]) m_fe = 1'b0;
    m_arm = '0;
  endtask

  task automatic read_all(input string tag);
    logic [15:0] d;
    chk({tag, " R10 irq"}, 16'(irq), 16'(m_rdrf | m_brf | m_ov));
    bus_read(1'b0, d);
    chk({tag, " status"}, d, exp_stat(1'b1, 1'b1));
    model_stat_read();
    bus_read(1'b1, d);
    chk({tag, " data"}, d, {8'h00, m_data});
    model_data_read();
    @(negedge clk);
  endtask

  task automatic tx_capture(output logic [7:0] d, output logic stopv);
    int guard = 0;
    while (tx && guard < 100) begin @(negedge clk); guard++; end
    repeat (BIT/2) @(negedge clk);
    chk("R8 start bit", 16'(tx), 16'd0);
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk);
      d[i] = tx;
    end
    repeat (BIT) @(negedge clk);
    stopv = tx;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [7:0] tb, b;
    logic sv, lowseen;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 tx in reset", 16'(tx), 16'd1);
    chk("R1 irq in reset", 16'(irq), 16'd0);
    chk("R1 rdata in reset", reg_rdata, 16'd0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    bus_read(1'b0, d);
    chk("R1 status after reset", d, 16'h00C0);

    // R2 glitch shorter than half a bit
    rx = 1'b0; repeat (6) @(negedge clk); rx = 1'b1;
    repeat (2*BIT) @(negedge clk);
    bus_read(1'b0, d);
    chk("R2 glitch ignored", d, 16'h00C0);

    // R3 plain frame
    send_frame(8'hA5, 1'b1, 1'b0);
    read_all("R3 frame");

    // R4 framing error with data
    send_frame(8'h3C, 1'b0, 1'b0);
    read_all("R4 framing");

    // R5 break, normal mode
    send_frame(8'h00, 1'b0, 1'b0);
    read_all("R5 break");

    // R5 LIN mode: ninth bit 1 -> no break, then real LIN break
    lin = 1'b1;
    send_frame(8'h00, 1'b0, 1'b1);
    read_all("R5 lin no-break");
    send_frame(8'h00, 1'b0, 1'b0);
    read_all("R5 lin break");
    lin = 1'b0;

    // R6 data read alone clears nothing
    send_frame(8'h5A, 1'b1, 1'b0);
    bus_read(1'b1, d);
    model_data_read();
    bus_read(1'b0, d);
    chk("R6 data-only read kept flags", d, exp_stat(1'b1, 1'b1));
    model_stat_read();
    bus_read(1'b1, d);
    model_data_read();
    @(negedge clk);
    bus_read(1'b0, d);
    chk("R6 cleared after sequence", d, 16'h00C0);
    model_stat_read();
    @(negedge clk);
    chk("R10 irq low after clear", 16'(irq), 16'd0);

    // R7 overrun keeps old byte
    send_frame(8'h11, 1'b1, 1'b0);
    send_frame(8'h22, 1'b1, 1'b0);
    read_all("R7 overrun");

    // R9 measurement mode suppresses flags
    meas = 1'b1;
    send_frame(8'h77, 1'b1, 1'b0);
    send_frame(8'h00, 1'b0, 1'b0);
    meas = 1'b0;
    read_all("R9 meas");

    // R8 transmit with mid-frame status read
    fork
      bus_write(8'hC3);
      begin
        tx_capture(tb, sv);
        chk("R8 tx byte", 16'(tb), 16'h00C3);
        chk("R8 tx stop", 16'(sv), 16'd1);
      end
      begin
        repeat (3*BIT) @(negedge clk);
        bus_read(1'b0, d);
        model_stat_read();
        chk("R8 tc low while sending", d, exp_stat(1'b1, 1'b0));
      end
    join
    repeat (BIT) @(negedge clk);
    bus_read(1'b0, d);
    model_stat_read();
    chk("R8 tc back high", d, 16'h00C0);

    // R8 second write while holding full is ignored
    @(negedge clk); reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h81;
    @(negedge clk); reg_wdata = 8'h7E;
    @(negedge clk); reg_wr = 1'b0;
    tx_capture(tb, sv);
    chk("R8 first byte sent", 16'(tb), 16'h0081);
    lowseen = 1'b0;
    repeat (3*BIT) begin @(negedge clk); if (!tx) lowseen = 1'b1; end
    chk("R8 ignored write not sent", 16'(lowseen), 16'd0);

    // R8 random transmit bytes
    for (int k = 0; k < 5; k++) begin
      b = 8'($urandom);
      bus_write(b);
      tx_capture(tb, sv);
      chk("R8 random tx", 16'(tb), 16'(b));
      repeat (2*BIT) @(negedge clk);
    end

    // Random receive traffic (R3, R4, R5, R6, R7)
    for (int k = 0; k < 40; k++) begin
      int mode;
      logic stopb, extra;
      if (k % 10 == 0) lin = 1'($urandom);
      b = ($urandom % 6 == 0) ? 8'h00 : 8'($urandom);
      stopb = ($urandom % 4) != 0;
      extra = 1'($urandom);
      send_frame(b, stopb, extra);
      mode = $urandom % 4;
      if (mode == 1) begin
        bus_read(1'b1, d);
        chk("R6 random data read", d, {8'h00, m_data});
        model_data_read();
      end
      if (mode != 0) read_all("R3 random");
    end
    read_all("R7 final");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule